// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external asynchronous static RAM with a 17-bit address and an 8-bit data bus. The host hands over one request at a time: an address, a write flag and, for a write, a byte. The controller turns that request into a timed sequence on the RAM pins and, for a read, returns the byte with a one-clock valid pulse. The RAM pins are two chip selects of opposite polarity, an active-low write strobe and an active-low output enable. The data bus is presented as a separate input, output and output-enable, so that the pad ring can build the bidirectional pin.

Every phase length is a count of clocks. Each count is derived at elaboration time from nanosecond limits and the clock period, rounding up, with a floor of one clock. With the default 4 ns clock the counts are as follows:
- Write: one address-setup clock, eight write-strobe-low clocks and one hold clock.
- Read: ten access clocks, followed by four bus-release clocks.
- Start-up: ten recovery clocks after reset.

Between requests the RAM is deselected with its outputs disabled, which puts it in standby.

Top module: `asram_ctl`

## Requirements
- R1: After reset is released, `host_ready` stays low for exactly 10 clocks of recovery and then rises.
- R2: While no access is in progress (recovery or idle), the pins are `ram_cs_n`=1, `ram_cs`=0, `ram_we_n`=1, `ram_oe_n`=1 and `ram_dq_oe`=0.
- R3: A write shows the following pin sequence, with both selects active and `ram_addr` equal to the request address throughout: one clock with `ram_we_n`=1, then 8 clocks with `ram_we_n`=0, then one hold clock with `ram_we_n`=1. `ram_we_n` is low only while both selects are active.
- R4: During a write, `ram_oe_n` stays 1 for the whole sequence. `ram_dq_oe`=1 with `ram_dq_out` equal to the request byte from the first strobe-low clock through the hold clock. `ram_dq_oe` is never 1 while `ram_oe_n` is 0.
- R5: A read holds both selects active, with `ram_we_n`=1, `ram_oe_n`=0 and `ram_addr` equal to the request address, for 10 clocks. The byte on `ram_dq_in` is captured at the clock edge that ends those 10 clocks. It appears on `host_rdata` with `host_rvalid`=1 for exactly one clock, in the clock that follows the access.
- R6: After a read access, the RAM is deselected with `ram_oe_n`=1 and `ram_dq_oe`=0 for 4 clocks before `host_ready` rises again. A following write therefore cannot drive the bus earlier.
- R7: `host_ready` falls in the clock after a request is accepted (`host_valid` and `host_ready` both 1 at a clock edge). It stays low for 10 clocks for a write and 14 clocks for a read.
- R8: A request presented while `host_ready` is 0 is ignored. The running access keeps its pins and address, and after it ends no access starts unless a request is presented again.
- R9: Requests complete in order. A read returns the byte of the most recent write to that address, including after repeated writes to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Host request present |
| host_ready | output | 1 | Controller can accept a request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Request address |
| host_wdata | input | 8 | Write byte |
| host_rvalid | output | 1 | One-clock pulse with read byte |
| host_rdata | output | 8 | Read byte |
| ram_addr | output | 17 | RAM address pins |
| ram_cs_n | output | 1 | Active-low chip select |
| ram_cs | output | 1 | Active-high chip select |
| ram_we_n | output | 1 | Active-low write strobe |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_dq_out | output | 8 | Data driven toward the RAM |
| ram_dq_oe | output | 1 | Drive enable for the data pins |
| ram_dq_in | input | 8 | Data returned by the RAM |

## Verification
The bench places a RAM model behind the pins. The model returns a garbage byte until the read conditions have held for the full access time, so a controller that samples early returns the wrong byte. Directed cases cover the following:
- The lowest and highest address, and the all-zero and all-ones bytes, which show up stuck or swapped address and data bits.
- A read followed by a write, which shows whether the bus-release gap is kept.
- Repeated writes to one address, which show whether the last write wins.
- A request raised in the middle of a write, which shows whether a busy controller ignores it.

A seeded random mix of reads and writes follows. Its addresses are drawn half from a small reused pool and half from the full range, and it checks the whole pin waveform of every access, clock by clock, against tables computed in the bench.

// File: rtl/asram_pkg.sv
// Package: shared phase type and cycle arithmetic for the asynchronous
// SRAM controller. Assumes all timing limits are non-negative integers in ns.
package asram_pkg;

    typedef enum logic [2:0] {
        PH_RECOVER = 3'd0,
        PH_IDLE    = 3'd1,
        PH_WSETUP  = 3'd2,
        PH_WSTROBE = 3'd3,
        PH_WHOLD   = 3'd4,
        PH_RACCESS = 3'd5,
        PH_RGAP    = 3'd6
    } phase_e;

    // Clocks needed to cover a time limit, rounded up, never below one.
    function automatic int clocks_for(input int lim_ns, input int clk_ns);
        int r;
        r = (lim_ns + clk_ns - 1) / clk_ns;
        return (r < 1) ? 1 : r;
    endfunction

    // Larger of two counts.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
// Phase timer: a loadable down-counter that flags the last clock of a phase.
// Assumes the caller loads (length - 1) on the clock that enters a phase.
module asram_phase_timer #(
    parameter int CNT_W   = 4,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    // Count down to zero; reload on phase entry; reset to the recovery length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

    // The counter never wraps below zero.
    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_q) == '0 && !$past(load)) |-> (cnt_q == '0)); // R7

endmodule

// File: rtl/asram_sequencer.sv
// Sequencer: steps through recovery, idle and the write and read phases.
// Accepts one request when idle. Assumes the timer reports the last clock of
// each phase one clock after it is loaded with (length - 1).
module asram_sequencer
    import asram_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int SETUP_CYC = 1,
    parameter int STROBE_CYC = 8,
    parameter int HOLD_CYC  = 1,
    parameter int ACCESS_CYC = 10,
    parameter int GAP_CYC   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_valid,
    input  logic             host_write,
    input  logic             last,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             accept,
    output logic             capture,
    output logic             ready,
    output phase_e           phase
);

    phase_e phase_q, phase_d;

    // Next-phase decision and timer load for the phase being entered.
    always_comb begin
        phase_d  = phase_q;
        load     = 1'b0;
        load_val = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        case (phase_q)
            PH_RECOVER: begin
                if (last) phase_d = PH_IDLE;
            end
            PH_IDLE: begin
                if (host_valid) begin
                    accept = 1'b1;
                    load   = 1'b1;
                    if (host_write) begin
                        phase_d  = PH_WSETUP;
                        load_val = CNT_W'(SETUP_CYC - 1);
                    end else begin
                        phase_d  = PH_RACCESS;
                        load_val = CNT_W'(ACCESS_CYC - 1);
                    end
                end
            end
            PH_WSETUP: begin
                if (last) begin
                    phase_d  = PH_WSTROBE;
                    load     = 1'b1;
                    load_val = CNT_W'(STROBE_CYC - 1);
                end
            end
            PH_WSTROBE: begin
                if (last) begin
                    phase_d  = PH_WHOLD;
                    load     = 1'b1;
                    load_val = CNT_W'(HOLD_CYC - 1);
                end
            end
            PH_WHOLD: begin
                if (last) phase_d = PH_IDLE;
            end
            PH_RACCESS: begin
                if (last) begin
                    capture  = 1'b1;
                    phase_d  = PH_RGAP;
                    load     = 1'b1;
                    load_val = CNT_W'(GAP_CYC - 1);
                end
            end
            PH_RGAP: begin
                if (last) phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register; reset enters recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_RECOVER;
        else        phase_q <= phase_d;
    end

    assign phase = phase_q;
    assign ready = (phase_q == PH_IDLE);

    // An accepted request always leaves the idle phase on the next clock.
    AST_ACCEPT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && host_valid) |=> !ready); // R7
    // Recovery is entered only from reset.
    AST_NO_REENTER_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_RECOVER) |=> (phase_q != PH_RECOVER)); // R1

endmodule

// File: rtl/asram_pin_drive.sv
// Pin driver: holds the request address and byte, decodes the phase into the
// RAM control pins and captures the read byte. Assumes the phase input is a
// register output, so every pin changes only at a clock edge.
module asram_pin_drive
    import asram_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int STROBE_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ram_dq_in,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_cs_n,
    output logic              ram_cs,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);

    localparam int LOW_W = $clog2(STROBE_CYC + 2);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;
    logic              selected;
    logic [LOW_W-1:0]  we_low_q;

    // Latch the request address and byte when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Capture the read byte at the end of the access; pulse valid once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= capture;
            if (capture) rdata_q <= ram_dq_in;
        end
    end

    // Decode the phase into select, strobe, output-enable and drive pins.
    always_comb begin
        selected   = (phase == PH_WSETUP) || (phase == PH_WSTROBE) ||
                     (phase == PH_WHOLD)  || (phase == PH_RACCESS);
        ram_cs_n   = !selected;
        ram_cs     = selected;
        ram_we_n   = (phase != PH_WSTROBE);
        ram_oe_n   = (phase != PH_RACCESS);
        ram_dq_oe  = (phase == PH_WSTROBE) || (phase == PH_WHOLD);
        ram_addr   = addr_q;
        ram_dq_out = wdata_q;
    end

    assign rvalid = rvalid_q;
    assign rdata  = rdata_q;

    // Length of the current write-strobe-low run, for the pulse-width check.
    always_ff @(posedge clk) begin
        if (!rst_n)         we_low_q <= '0;
        else if (!ram_we_n) we_low_q <= (we_low_q == '1) ? we_low_q : we_low_q + 1'b1;
        else                we_low_q <= '0;
    end

    AST_STROBE_INSIDE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (!ram_cs_n && ram_cs)); // R3
    AST_STROBE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> (we_low_q >= LOW_W'(STROBE_CYC))); // R3
    AST_ADDR_HELD_AT_WRITE_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> ($stable(ram_addr) && $stable(ram_dq_out) && ram_dq_oe)); // R3
    AST_DRIVE_DURING_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (ram_dq_oe && ram_oe_n)); // R4
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_oe |-> ram_oe_n); // R4
    AST_RVALID_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid); // R5
    AST_GAP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_oe_n) |-> (ram_cs_n && !ram_cs && !ram_dq_oe)); // R6

endmodule

// File: rtl/asram_ctl.sv
// Asynchronous SRAM interface controller (top). Serves one host request at a
// time and times the RAM pins from ns limits and the clock period.
// Assumes a single clock, a synchronous active-low reset, and a pad ring that
// builds the bidirectional data pins from ram_dq_out, ram_dq_oe and ram_dq_in.
module asram_ctl
    import asram_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 4,
    parameter int T_WCYC_NS = 35,
    parameter int T_WPUL_NS = 30,
    parameter int T_AVWE_NS = 30,
    parameter int T_DSU_NS  = 20,
    parameter int T_ASU_NS  = 0,
    parameter int T_AHLD_NS = 3,
    parameter int T_RCYC_NS = 40,
    parameter int T_AACC_NS = 40,
    parameter int T_CACC_NS = 40,
    parameter int T_OACC_NS = 12,
    parameter int T_OREL_NS = 10,
    parameter int T_CREL_NS = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    output logic              host_ready,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_cs_n,
    output logic              ram_cs,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in
);

    localparam int SETUP_CYC  = clocks_for(T_ASU_NS, CLK_NS);
    localparam int HOLD_CYC   = clocks_for(T_AHLD_NS, CLK_NS);
    localparam int STROBE_MIN = max2(max2(clocks_for(T_WPUL_NS, CLK_NS),
                                          clocks_for(T_DSU_NS, CLK_NS)),
                                     clocks_for(T_AVWE_NS, CLK_NS));
    localparam int STROBE_CYC = max2(STROBE_MIN,
                                     clocks_for(T_WCYC_NS, CLK_NS) - SETUP_CYC - HOLD_CYC);
    localparam int ACCESS_CYC = max2(max2(clocks_for(T_RCYC_NS, CLK_NS),
                                          clocks_for(T_AACC_NS, CLK_NS)),
                                     max2(clocks_for(T_CACC_NS, CLK_NS),
                                          clocks_for(T_OACC_NS, CLK_NS)));
    localparam int GAP_CYC    = max2(clocks_for(T_OREL_NS, CLK_NS),
                                     clocks_for(T_CREL_NS, CLK_NS));
    localparam int RECOV_CYC  = clocks_for(T_RCYC_NS, CLK_NS);
    localparam int LONGEST    = max2(max2(STROBE_CYC, ACCESS_CYC),
                                     max2(max2(GAP_CYC, RECOV_CYC),
                                          max2(SETUP_CYC, HOLD_CYC)));
    localparam int CNT_W      = $clog2(LONGEST + 1);

    logic             t_load;
    logic [CNT_W-1:0] t_load_val;
    logic             t_last;
    logic             accept;
    logic             capture;
    phase_e           phase;

    asram_phase_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (RECOV_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_load_val),
        .last     (t_last)
    );

    asram_sequencer #(
        .CNT_W      (CNT_W),
        .SETUP_CYC  (SETUP_CYC),
        .STROBE_CYC (STROBE_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .ACCESS_CYC (ACCESS_CYC),
        .GAP_CYC    (GAP_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_valid (host_valid),
        .host_write (host_write),
        .last       (t_last),
        .load       (t_load),
        .load_val   (t_load_val),
        .accept     (accept),
        .capture    (capture),
        .ready      (host_ready),
        .phase      (phase)
    );

    asram_pin_drive #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .STROBE_CYC (STROBE_CYC)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .accept     (accept),
        .capture    (capture),
        .req_addr   (host_addr),
        .req_wdata  (host_wdata),
        .ram_dq_in  (ram_dq_in),
        .ram_addr   (ram_addr),
        .ram_cs_n   (ram_cs_n),
        .ram_cs     (ram_cs),
        .ram_we_n   (ram_we_n),
        .ram_oe_n   (ram_oe_n),
        .ram_dq_out (ram_dq_out),
        .ram_dq_oe  (ram_dq_oe),
        .rvalid     (host_rvalid),
        .rdata      (host_rdata)
    );

    // When the host may issue, the RAM is in standby.
    AST_READY_MEANS_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (ram_cs_n && !ram_cs && ram_oe_n && ram_we_n && !ram_dq_oe)); // R2
    // A busy controller leaves the address pins alone when a request arrives.
    AST_BUSY_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_ready && !ram_cs_n && $past(!host_ready)) |-> $stable(ram_addr)); // R8

endmodule

// File: tb/asram_ctl_tb.sv
`timescale 1ns/1ps
// Bench: RAM model behind the pins, directed corners plus a seeded random mix.
module asram_ctl_tb;

    localparam int AW = 17;
    localparam int DW = 8;
    localparam int EXP_STROBE = 8;   // 30 ns / 4 ns rounded up
    localparam int EXP_ACCESS = 10;  // 40 ns / 4 ns
    localparam int EXP_GAP    = 4;   // 15 ns / 4 ns rounded up
    localparam int EXP_RECOV  = 10;  // 40 ns / 4 ns

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_valid = 1'b0;
    logic          host_write = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_ready, host_rvalid;
    logic [DW-1:0] host_rdata;
    logic [AW-1:0] ram_addr;
    logic          ram_cs_n, ram_cs, ram_we_n, ram_oe_n, ram_dq_oe;
    logic [DW-1:0] ram_dq_out;
    logic [DW-1:0] ram_dq_in;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    logic [DW-1:0] ram_model [logic [AW-1:0]];
    logic [DW-1:0] exp_mem   [logic [AW-1:0]];
    int            rd_run = 0;

    always #2 clk = ~clk;

    asram_ctl u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_cs(ram_cs),
        .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
        .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
    );

    function automatic logic [DW-1:0] fill_byte(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [AW-1:0] pool_addr(input int i);
        return AW'(i * 17'h0B5A3 + 17'h00101);
    endfunction

    // RAM model: stores while selected with strobe low and data driven;
    // returns valid data only after the full access time of a stable read.
    wire read_cond = !ram_cs_n && ram_cs && ram_we_n && !ram_oe_n;
    always @(posedge clk) begin
        if (!ram_cs_n && ram_cs && !ram_we_n && ram_dq_oe)
            ram_model[ram_addr] = ram_dq_out;
        if (read_cond) rd_run <= (rd_run >= 20) ? 20 : rd_run + 1;
        else           rd_run <= 0;
    end
    always @* begin
        if (read_cond && rd_run >= EXP_ACCESS - 1)
            ram_dq_in = ram_model.exists(ram_addr) ? ram_model[ram_addr] : fill_byte(ram_addr);
        else
            ram_dq_in = 8'hEE;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Pin vector {cs_n, cs, we_n, oe_n, dq_oe, ready, rvalid}.
    function automatic logic [6:0] pins();
        return {ram_cs_n, ram_cs, ram_we_n, ram_oe_n, ram_dq_oe, host_ready, host_rvalid};
    endfunction

    // Expected write-cycle pins, observation i after the accept edge.
    function automatic logic [6:0] exp_wr(input int i);
        if (i == 0)                return 7'b0111000;
        if (i <= EXP_STROBE)       return 7'b0101100;
        if (i == EXP_STROBE + 1)   return 7'b0111100;
        return 7'b1011010;
    endfunction

    // Expected read-cycle pins, observation i after the accept edge.
    function automatic logic [6:0] exp_rd(input int i);
        if (i < EXP_ACCESS)            return 7'b0110000;
        if (i == EXP_ACCESS)           return 7'b1011001;
        if (i < EXP_ACCESS + EXP_GAP)  return 7'b1011000;
        return 7'b1011010;
    endfunction

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke);
        host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk);
        for (int i = 0; i <= EXP_STROBE + 2; i++) begin
            @(negedge clk);
            if (i == 0) begin host_valid = 1'b0; host_addr = ~a; host_wdata = ~d; end
            chk(pins() == exp_wr(i), "R3 R7 write pins", 32'(pins()), 32'(exp_wr(i)));
            if (i <= EXP_STROBE + 1)
                chk(ram_addr == a, "R3 write address", 32'(ram_addr), 32'(a));
            if (i >= 1 && i <= EXP_STROBE + 1)
                chk(ram_dq_out == d, "R4 write data", 32'(ram_dq_out), 32'(d));
            if (poke && i == 3) begin
                host_valid = 1'b1; host_write = 1'b0; host_addr = a ^ 17'h1;
            end
            if (poke && i == 6) host_valid = 1'b0;
        end
        exp_mem[a] = d;
        if (poke) begin
            @(negedge clk);
            chk(pins() == 7'b1011010, "R8 busy request ignored", 32'(pins()), 32'h5A);
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        logic [DW-1:0] e;
        e = exp_mem.exists(a) ? exp_mem[a] : fill_byte(a);
        host_valid = 1'b1; host_write = 1'b0; host_addr = a;
        @(posedge clk);
        for (int i = 0; i <= EXP_ACCESS + EXP_GAP; i++) begin
            @(negedge clk);
            if (i == 0) begin host_valid = 1'b0; host_addr = ~a; end
            chk(pins() == exp_rd(i), "R5 R6 R7 read pins", 32'(pins()), 32'(exp_rd(i)));
            if (i < EXP_ACCESS)
                chk(ram_addr == a, "R5 read address", 32'(ram_addr), 32'(a));
            if (i == EXP_ACCESS)
                chk(host_rdata == e, "R5 R9 read byte", 32'(host_rdata), 32'(e));
        end
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog R7: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int wait_n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(pins() == 7'b1011000, "R2 pins in reset", 32'(pins()), 32'h58);
        rst_n = 1'b1;
        wait_n = 0;
        for (int n = 1; n <= 30; n++) begin
            @(negedge clk);
            if (n == 1) chk(pins() == 7'b1011000, "R1 R2 recovery pins", 32'(pins()), 32'h58);
            if (host_ready) begin wait_n = n; break; end
        end
        chk(wait_n == EXP_RECOV, "R1 recovery length", 32'(wait_n), 32'(EXP_RECOV));
        chk(pins() == 7'b1011010, "R2 idle standby", 32'(pins()), 32'h5A);

        // Directed corners.
        do_write(17'h00000, 8'h00, 1'b0);
        do_write(17'h1FFFF, 8'hFF, 1'b0);
        do_read(17'h1FFFF);
        do_read(17'h00000);
        do_read(17'h0A5A5);                 // never written
        do_write(17'h0A5A5, 8'hC3, 1'b0);   // write right after a read: R6
        do_write(17'h0A5A5, 8'h3C, 1'b0);   // repeated write, last wins: R9
        do_read(17'h0A5A5);
        do_write(17'h15555, 8'h96, 1'b1);   // request raised while busy: R8
        do_read(17'h15555);

        // Seeded random mix.
        for (int k = 0; k < 80; k++) begin
            logic [31:0] r;
            logic [AW-1:0] a;
            r = $urandom;
            a = r[0] ? pool_addr(int'($urandom % 8)) : AW'($urandom);
            if (r[1]) do_write(a, DW'($urandom), 1'b0);
            else      do_read(a);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule